// File: doc/BRIEF.md
# Iterative Greatest Common Divisor Engine

This block finds the greatest common divisor of two unsigned integers. It never divides. It repeats two simple steps. When the first operand is smaller than the second, the two operands trade places. Otherwise the second operand is subtracted from the first. The loop stops when the second operand reaches zero, and the first operand then holds the answer. One step runs per clock cycle, so a result takes a number of cycles that depends on the data.

A producer offers an operand pair on a valid/ready handshake. The engine takes one pair, then refuses input until the result it produced has been collected. The result stays on the output with a valid flag until a consumer acknowledges it. After the acknowledge, the engine is ready for the next pair.

Top module: `gcd_iter`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `in_ready` is 1 and `out_valid` is 0.
- R2: A pair is taken only on a rising edge where `in_valid` and `in_ready` are both 1. From that edge until the result is acknowledged, `in_ready` is 0. Values on `in_valid`, `in_a` and `in_b` in that period do not change the result.
- R3: For two nonzero operands, `out_value` equals their greatest common divisor whenever `out_valid` is 1.
- R4: When both operands are zero the result is 0. When exactly one operand is zero, the result is the other operand.
- R5: Once `out_valid` is 1, it stays 1 and `out_value` stays unchanged until a rising edge where `out_ack` is 1. After that edge `out_valid` is 0 and `in_ready` is 1.
- R6: `in_ready` and `out_valid` are never 1 in the same cycle.
- R7: Let N be the number of loop iterations, where the final iteration is the one that finds the second operand at zero. Then `out_valid` rises exactly N rising edges after the edge that accepted the pair. Each swap counts as one iteration and each subtraction counts as one iteration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer offers an operand pair |
| in_ready | output | 1 | Engine can take a pair this cycle |
| in_a | input | W | First operand (unsigned) |
| in_b | input | W | Second operand (unsigned) |
| out_valid | output | 1 | Result is available |
| out_ack | input | 1 | Consumer takes the result |
| out_value | output | W | Result value |

## Verification
The assertions assume the consumer raises `out_ack` only while `out_valid` is high. They also assume the producer's signals matter only on the accepting edge. The stimulus follows both rules: `out_ack` is driven only after `out_valid` has been seen high, and it is held for a single cycle. The stimulus also drives random values and random `in_valid` pulses on the operand inputs while the engine is busy. This exercises the rule that such input is ignored. Random operands are held to 10 bits so every run stays short. A few full-width corner pairs are applied directly, with random delays before each acknowledge.

// File: rtl/gcd_iter_pkg.sv
package gcd_iter_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_HOLD = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        A_FROM_IN   = 2'd0,
        A_FROM_B    = 2'd1,
        A_FROM_DIFF = 2'd2
    } a_src_e;

    typedef enum logic {
        B_FROM_IN = 1'b0,
        B_FROM_A  = 1'b1
    } b_src_e;

    typedef struct packed {
        logic   a_en;
        logic   b_en;
        a_src_e a_src;
        b_src_e b_src;
    } ctrl_t;

    typedef struct packed {
        logic b_zero;
        logic a_lt_b;
    } flags_t;

    localparam ctrl_t CTRL_NOP = '{a_en: 1'b0, b_en: 1'b0,
                                  a_src: A_FROM_IN, b_src: B_FROM_IN};

endpackage

// File: rtl/gcd_iter_reg.sv
module gcd_iter_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (en) begin
            q <= d;
        end
    end
endmodule

// File: rtl/gcd_iter_dpath.sv
module gcd_iter_dpath
    import gcd_iter_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  ctrl_t        ctrl,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output flags_t       flags,
    output logic [W-1:0] result
);
    logic [W-1:0] reg_a, reg_b;
    logic [W-1:0] next_a, next_b;
    logic [W-1:0] diff;

    assign diff = reg_a - reg_b;

    always_comb begin
        case (ctrl.a_src)
            A_FROM_B:    next_a = reg_b;
            A_FROM_DIFF: next_a = diff;
            default:     next_a = op_a;
        endcase
    end

    always_comb begin
        case (ctrl.b_src)
            B_FROM_A: next_b = reg_a;
            default:  next_b = op_b;
        endcase
    end

    gcd_iter_reg #(.W(W)) u_reg_a (
        .clk (clk),
        .en  (ctrl.a_en),
        .d   (next_a),
        .q   (reg_a)
    );

    gcd_iter_reg #(.W(W)) u_reg_b (
        .clk (clk),
        .en  (ctrl.b_en),
        .d   (next_b),
        .q   (reg_b)
    );

    assign flags.b_zero = (reg_b == '0);
    assign flags.a_lt_b = (reg_a < reg_b);
    assign result       = reg_a;
endmodule

// File: rtl/gcd_iter_ctrl.sv
module gcd_iter_ctrl
    import gcd_iter_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  logic   out_ack,
    input  flags_t flags,
    output ctrl_t  ctrl,
    output logic   in_ready,
    output logic   out_valid
);
    state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (in_valid)     state_nx = ST_CALC;
            ST_CALC: if (flags.b_zero) state_nx = ST_HOLD;
            ST_HOLD: if (out_ack)      state_nx = ST_IDLE;
            default:                   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        ctrl      = CTRL_NOP;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        case (state)
            ST_IDLE: begin
                in_ready   = 1'b1;
                ctrl.a_en  = 1'b1;
                ctrl.b_en  = 1'b1;
                ctrl.a_src = A_FROM_IN;
                ctrl.b_src = B_FROM_IN;
            end
            ST_CALC: begin
                if (flags.a_lt_b) begin
                    ctrl.a_en  = 1'b1;
                    ctrl.b_en  = 1'b1;
                    ctrl.a_src = A_FROM_B;
                    ctrl.b_src = B_FROM_A;
                end else if (!flags.b_zero) begin
                    ctrl.a_en  = 1'b1;
                    ctrl.a_src = A_FROM_DIFF;
                end
            end
            ST_HOLD: begin
                out_valid = 1'b1;
            end
            default: begin
                ctrl = CTRL_NOP;
            end
        endcase
    end
endmodule

// File: rtl/gcd_iter.sv
module gcd_iter
    import gcd_iter_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic         out_valid,
    input  logic         out_ack,
    output logic [W-1:0] out_value
);
    ctrl_t  ctrl;
    flags_t flags;

    gcd_iter_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ack   (out_ack),
        .flags     (flags),
        .ctrl      (ctrl),
        .in_ready  (in_ready),
        .out_valid (out_valid)
    );

    gcd_iter_dpath #(.W(W)) u_dpath (
        .clk    (clk),
        .ctrl   (ctrl),
        .op_a   (in_a),
        .op_b   (in_b),
        .flags  (flags),
        .result (out_value)
    );
endmodule

// File: rtl/gcd_iter_chk.sv
module gcd_iter_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_ready,
    input logic [W-1:0] in_a,
    input logic [W-1:0] in_b,
    input logic         out_valid,
    input logic         out_ack,
    input logic [W-1:0] out_value
);
    // R6: the two handshake sides are never open together
    assert_excl_sides_R6: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    // R2: after an accepted pair, input side closes
    assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R5: result held until acknowledged
    assert_hold_result_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ack) |=> (out_valid && $stable(out_value)));

    // R5: acknowledge releases the result and reopens input
    assert_release_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ack) |=> (!out_valid && in_ready));

    // R4: a zero second operand finishes in one step with the first operand
    assert_zero_b_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_b == '0) |=> ##1 (out_valid && out_value == $past(in_a, 2)));
endmodule

bind gcd_iter gcd_iter_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_ack   (out_ack),
    .out_value (out_value)
);

// File: tb/sim_gcd_iter.sv
`timescale 1ns/1ps
module sim_gcd_iter;
    localparam int W = 16;
    localparam int LIMIT = 190000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         out_valid;
    logic         out_ack = 1'b0;
    logic [W-1:0] out_value;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gcd_iter #(.W(W)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ack(out_ack),
        .out_value(out_value)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > LIMIT && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual cycles %0d expected below %0d", cycles, LIMIT);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int ref_gcd(int a, int b);
        int x = a;
        int y = b;
        while (y != 0) begin
            int t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    function automatic int ref_steps(int a, int b);
        int x = a;
        int y = b;
        int n = 1;
        while (y != 0) begin
            if (x < y) begin
                int t = x;
                x = y;
                y = t;
            end else begin
                x = x - y;
            end
            n = n + 1;
        end
        return n;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_pair(int a, int b);
        int c = 0;
        int d;
        logic [W-1:0] held;
        @(negedge clk);
        check(in_ready == 1'b1, "R6 ready before offer", in_ready, 1);
        in_a = a[W-1:0];
        in_b = b[W-1:0];
        in_valid = 1'b1;
        @(negedge clk);
        while (!out_valid) begin
            check(in_ready == 1'b0, "R2 ready low while busy", in_ready, 0);
            c = c + 1;
            in_valid = 1'($urandom_range(0, 1));
            in_a = W'($urandom);
            in_b = W'($urandom);
            @(negedge clk);
        end
        in_valid = 1'b0;
        if (a == 0 || b == 0)
            check(out_value == W'(a | b), "R4 zero operand", out_value, a | b);
        else
            check(out_value == W'(ref_gcd(a, b)), "R3 gcd value", out_value, ref_gcd(a, b));
        check(c == ref_steps(a, b), "R7 latency", c, ref_steps(a, b));
        check(in_ready == 1'b0, "R6 ready low with result", in_ready, 0);
        held = out_value;
        d = $urandom_range(0, 3);
        for (int i = 0; i < d; i++) begin
            @(negedge clk);
            check(out_valid == 1'b1 && out_value == held, "R5 held", out_value, held);
        end
        out_ack = 1'b1;
        @(negedge clk);
        out_ack = 1'b0;
        check(out_valid == 1'b0 && in_ready == 1'b1, "R5 release", {out_valid, in_ready}, 1);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R1 during reset", {in_ready, out_valid}, 2);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R1 after reset", {in_ready, out_valid}, 2);

        // R2: no acceptance without in_valid
        for (int i = 0; i < 5; i++) begin
            in_a = W'($urandom);
            in_b = W'($urandom);
            @(negedge clk);
            check(out_valid == 1'b0 && in_ready == 1'b1, "R2 idle without valid",
                  {out_valid, in_ready}, 1);
        end

        run_pair(0, 0);
        run_pair(0, 37);
        run_pair(91, 0);
        run_pair(48, 18);
        run_pair(18, 48);
        run_pair(65535, 65535);
        run_pair(1, 1);
        run_pair(65535, 1);
        run_pair(65521, 65519);
        run_pair(40960, 61440);

        for (int i = 0; i < 60; i++) begin
            run_pair($urandom_range(1, 1023), $urandom_range(1, 1023));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule